// File: doc/BRIEF.md
# Interrupt Source Routing Matrix

This block collects fifteen external interrupt pins and nineteen on-chip peripheral interrupt lines, and turns them into twenty-two request lines for the downstream maskable interrupt channels and one non-maskable interrupt (NMI) line. Each of the 34 sources has three settings. A channel enable gates the source onto a maskable channel. A separate NMI enable gates it onto the NMI. A destination field names the channel it drives. External pins also have a polarity bit, so an active-low pin can be seen as active-high.

Some internal sources have fixed limits on where they may go. Two of them may only raise the NMI: the memory controller's uncorrectable-error line and the host bridge's NMI-only line. One may never raise the NMI: the memory controller's correctable-error line. The host bridge's general line may go to either kind of destination. The settings sit in a small register file behind a plain synchronous address, write strobe and data port. No data stream flows through the block, so it has no valid/ready handshake. All pins are plain level signals, and both outputs are registered once.

Sources are numbered 0 to 14 for the external pins and 15 to 33 for the internal lines, where internal line k is source 15+k. Internal lines 0 to 3 are, in order: bridge general, bridge NMI-only, correctable error and uncorrectable error.

Top module: `irq_route_matrix`

## Requirements
- R1: After a synchronous active-high reset, every channel output and the NMI output are 0, and every register reads 0: enables clear, polarity active-high, destinations 0.
- R2: A source whose channel enable is set and whose destination field holds d, with 1 <= d <= 22, drives `chan_irq_out[d-1]` while its corrected level is 1.
- R3: A destination value of 0, or of 23 and above, drives no channel.
- R4: A cleared channel enable keeps the source off every channel but does not affect its path to the NMI.
- R5: For external pin i, polarity bit i = 1 inverts the raw pin and 0 passes it unchanged. Internal sources are never inverted, and the polarity register holds only 15 bits.
- R6: Each channel output is the OR of all sources that qualify for that channel.
- R7: `nmi_out` is the OR of all NMI-capable sources whose NMI enable is set and whose corrected level is 1. The channel enable plays no part in this path.
- R8: Internal lines 1 and 3 (sources 16 and 18) never drive a maskable channel, whatever their settings.
- R9: Internal line 2 (source 17) never drives the NMI, but it may drive a maskable channel.
- R10: Register map. Address s (0 to 33) holds the 5-bit destination of source s in bits [4:0]. Address 34 holds the external channel enables [14:0]. Address 35 holds the internal channel enables [18:0], with bit k for internal line k. Address 36 holds the external NMI enables. Address 37 holds the internal NMI enables. Address 38 holds polarity [14:0]. A write stores the field bits, including a destination the source may not reach. `cfg_rdata` shows the register at `cfg_addr` one clock later, with unused bits 0.
- R11: The outputs change on the first rising edge after the input or setting that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_in | input | 15 | Raw external interrupt pins |
| int_irq_in | input | 19 | Internal peripheral interrupt lines, active-high |
| cfg_addr | input | 6 | Register address for read and write |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| chan_irq_out | output | 22 | Maskable channel requests, bit n-1 is channel n |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with its default parameters: 15 external pins, 19 internal lines, 22 channels, and the default capability masks that forbid internal lines 1 and 3 on the channels and internal line 2 on the NMI. These values let the bench reach both ends of the destination range (channels 1 and 22), the out-of-range codes 23 and 31, and the polarity register's 15-bit edge. They also let it reach every capability rule: the bridge general line going to both destinations, and the three lines that each have one destination forbidden.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Register offsets placed after the per-source destination registers
  localparam int OFS_EXT_EN  = 0;
  localparam int OFS_INT_EN  = 1;
  localparam int OFS_EXT_NMI = 2;
  localparam int OFS_INT_NMI = 3;
  localparam int OFS_POL     = 4;
  localparam int NUM_WORDS   = 5;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int N_EXT  = 15,
  parameter int N_INT  = 19,
  parameter int DEST_W = 5,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DATA_W-1:0]             rd_data,
  output logic [N_EXT+N_INT-1:0][DEST_W-1:0] dest_q,
  output logic [N_EXT-1:0]              ext_en_q,
  output logic [N_INT-1:0]              int_en_q,
  output logic [N_EXT-1:0]              ext_nmi_q,
  output logic [N_INT-1:0]              int_nmi_q,
  output logic [N_EXT-1:0]              pol_q
);
  localparam int N_SRC = N_EXT + N_INT;
  localparam logic [ADDR_W-1:0] A_EXT_EN  = ADDR_W'(N_SRC + OFS_EXT_EN);
  localparam logic [ADDR_W-1:0] A_INT_EN  = ADDR_W'(N_SRC + OFS_INT_EN);
  localparam logic [ADDR_W-1:0] A_EXT_NMI = ADDR_W'(N_SRC + OFS_EXT_NMI);
  localparam logic [ADDR_W-1:0] A_INT_NMI = ADDR_W'(N_SRC + OFS_INT_NMI);
  localparam logic [ADDR_W-1:0] A_POL     = ADDR_W'(N_SRC + OFS_POL);

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  // One destination register per source
  for (genvar s = 0; s < N_SRC; s++) begin : g_dest
    always_ff @(posedge clk) begin
      if (rst)
        dest_q[s] <= '0;
      else if (wr_en && addr == ADDR_W'(s))
        dest_q[s] <= wr_data[DEST_W-1:0];
    end
  end

  // Packed enable and polarity words
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_en_q  <= '0;
      int_en_q  <= '0;
      ext_nmi_q <= '0;
      int_nmi_q <= '0;
      pol_q     <= '0;
    end else if (wr_en) begin
      if (addr == A_EXT_EN)  ext_en_q  <= wr_data[N_EXT-1:0];
      if (addr == A_INT_EN)  int_en_q  <= wr_data[N_INT-1:0];
      if (addr == A_EXT_NMI) ext_nmi_q <= wr_data[N_EXT-1:0];
      if (addr == A_INT_NMI) int_nmi_q <= wr_data[N_INT-1:0];
      if (addr == A_POL)     pol_q     <= wr_data[N_EXT-1:0];
    end
  end

  // Read multiplexer, registered
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < N_SRC; s++)
      if (addr == ADDR_W'(s)) rd_mux = DATA_W'(dest_q[s]);
    if (addr == A_EXT_EN)  rd_mux = DATA_W'(ext_en_q);
    if (addr == A_INT_EN)  rd_mux = DATA_W'(int_en_q);
    if (addr == A_EXT_NMI) rd_mux = DATA_W'(ext_nmi_q);
    if (addr == A_INT_NMI) rd_mux = DATA_W'(int_nmi_q);
    if (addr == A_POL)     rd_mux = DATA_W'(pol_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/irq_route_cond.sv
module irq_route_cond #(
  parameter int N_EXT = 15,
  parameter int N_INT = 19,
  parameter logic [N_EXT+N_INT-1:0] CHAN_CAP = '1,
  parameter logic [N_EXT+N_INT-1:0] NMI_CAP  = '1
) (
  input  logic [N_EXT-1:0]       ext_in,
  input  logic [N_INT-1:0]       int_in,
  input  logic [N_EXT-1:0]       pol_q,
  input  logic [N_EXT+N_INT-1:0] chan_en,
  input  logic [N_EXT+N_INT-1:0] nmi_en,
  output logic [N_EXT+N_INT-1:0] chan_req,
  output logic [N_EXT+N_INT-1:0] nmi_req
);
  localparam int N_SRC = N_EXT + N_INT;

  logic [N_SRC-1:0] level;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    if (s < N_EXT) begin : g_ext
      // External pins pass through the polarity stage
      assign level[s] = ext_in[s] ^ pol_q[s];
    end else begin : g_int
      assign level[s] = int_in[s-N_EXT];
    end
    // Capability masks are constants; a forbidden path folds away
    if (CHAN_CAP[s]) begin : g_chan_ok
      assign chan_req[s] = level[s] & chan_en[s];
    end else begin : g_chan_no
      assign chan_req[s] = 1'b0;
    end
    if (NMI_CAP[s]) begin : g_nmi_ok
      assign nmi_req[s] = level[s] & nmi_en[s];
    end else begin : g_nmi_no
      assign nmi_req[s] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_route_combine.sv
module irq_route_combine #(
  parameter int N_SRC  = 34,
  parameter int N_CHAN = 22,
  parameter int DEST_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              chan_req,
  input  logic [N_SRC-1:0]              nmi_req,
  input  logic [N_SRC-1:0][DEST_W-1:0]  dest_q,
  output logic [N_CHAN-1:0]             chan_out,
  output logic                          nmi_out
);
  logic [N_CHAN-1:0] chan_hit;

  // Destination decode and per-channel OR; codes 0 and > N_CHAN match nothing
  always_comb begin
    chan_hit = '0;
    for (int c = 0; c < N_CHAN; c++)
      for (int s = 0; s < N_SRC; s++)
        if (chan_req[s] && dest_q[s] == DEST_W'(c + 1))
          chan_hit[c] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_out <= '0;
      nmi_out  <= 1'b0;
    end else begin
      chan_out <= chan_hit;
      nmi_out  <= |nmi_req;
    end
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
  parameter int N_EXT  = 15,
  parameter int N_INT  = 19,
  parameter int N_CHAN = 22,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter logic [N_INT-1:0] INT_CHAN_OK = 19'h7FFF5,
  parameter logic [N_INT-1:0] INT_NMI_OK  = 19'h7FFFB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_irq_in,
  input  logic [N_INT-1:0]  int_irq_in,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr_en,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [N_CHAN-1:0] chan_irq_out,
  output logic              nmi_out
);
  localparam int N_SRC  = N_EXT + N_INT;
  localparam int DEST_W = $clog2(N_CHAN + 1);
  localparam logic [N_SRC-1:0] CHAN_CAP = {INT_CHAN_OK, {N_EXT{1'b1}}};
  localparam logic [N_SRC-1:0] NMI_CAP  = {INT_NMI_OK,  {N_EXT{1'b1}}};

  logic [N_SRC-1:0][DEST_W-1:0] dest_q;
  logic [N_EXT-1:0] ext_en_q, ext_nmi_q, pol_q;
  logic [N_INT-1:0] int_en_q, int_nmi_q;
  logic [N_SRC-1:0] src_en_all, nmi_en_all, chan_req, nmi_req;

  assign src_en_all = {int_en_q, ext_en_q};
  assign nmi_en_all = {int_nmi_q, ext_nmi_q};

  irq_route_regs #(
    .N_EXT(N_EXT), .N_INT(N_INT), .DEST_W(DEST_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wr_data(cfg_wdata), .rd_data(cfg_rdata), .dest_q(dest_q),
    .ext_en_q(ext_en_q), .int_en_q(int_en_q), .ext_nmi_q(ext_nmi_q),
    .int_nmi_q(int_nmi_q), .pol_q(pol_q)
  );

  irq_route_cond #(
    .N_EXT(N_EXT), .N_INT(N_INT), .CHAN_CAP(CHAN_CAP), .NMI_CAP(NMI_CAP)
  ) u_cond (
    .ext_in(ext_irq_in), .int_in(int_irq_in), .pol_q(pol_q),
    .chan_en(src_en_all), .nmi_en(nmi_en_all),
    .chan_req(chan_req), .nmi_req(nmi_req)
  );

  irq_route_combine #(
    .N_SRC(N_SRC), .N_CHAN(N_CHAN), .DEST_W(DEST_W)
  ) u_comb (
    .clk(clk), .rst(rst), .chan_req(chan_req), .nmi_req(nmi_req),
    .dest_q(dest_q), .chan_out(chan_irq_out), .nmi_out(nmi_out)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int N_SRC  = 34,
  parameter int N_CHAN = 22,
  parameter int DEST_W = 5,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter logic [N_SRC-1:0] CHAN_CAP = '1,
  parameter logic [N_SRC-1:0] NMI_CAP  = '1
) (
  input logic              clk,
  input logic              rst,
  input logic [N_CHAN-1:0] chan_irq_out,
  input logic              nmi_out,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr_en,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic [N_SRC-1:0]  src_en,
  input logic [N_SRC-1:0]  nmi_en
);
  localparam logic [DATA_W-1:0] DEST_MASK = DATA_W'((1 << DEST_W) - 1);

  // R4: no channel enable means no channel request on the next edge
  p_chan_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |=> (chan_irq_out == '0));

  // R7: no NMI enable means no NMI on the next edge
  p_nmi_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (nmi_en == '0) |=> !nmi_out);

  // R8: only channel-capable enabled sources can raise a channel
  p_chan_cap_r8: assert property (@(posedge clk) disable iff (rst)
    ((src_en & CHAN_CAP) == '0) |=> (chan_irq_out == '0));

  // R9: only NMI-capable enabled sources can raise the NMI
  p_nmi_cap_r9: assert property (@(posedge clk) disable iff (rst)
    ((nmi_en & NMI_CAP) == '0) |=> !nmi_out);

  // R10: a written destination reads back after the read latency
  p_readback_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_addr < ADDR_W'(N_SRC))
      ##1 (!cfg_wr_en && cfg_addr == $past(cfg_addr))
      |=> (cfg_rdata == ($past(cfg_wdata, 2) & DEST_MASK)));
endmodule

bind irq_route_matrix irq_route_chk #(
  .N_SRC(N_SRC), .N_CHAN(N_CHAN), .DEST_W(DEST_W), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .CHAN_CAP(CHAN_CAP), .NMI_CAP(NMI_CAP)
) u_chk (
  .clk(clk), .rst(rst), .chan_irq_out(chan_irq_out), .nmi_out(nmi_out),
  .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .src_en(src_en_all), .nmi_en(nmi_en_all)
);

// File: tb/irq_route_matrix_test.sv
module irq_route_matrix_test;
  localparam int A_EXT_EN = 34, A_INT_EN = 35, A_EXT_NMI = 36;
  localparam int A_INT_NMI = 37, A_POL = 38;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] ext_irq_in = '0;
  logic [18:0] int_irq_in = '0;
  logic [5:0]  cfg_addr = '0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [21:0] chan_irq_out;
  logic        nmi_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_route_matrix uut (
    .clk(clk), .rst(rst), .ext_irq_in(ext_irq_in), .int_irq_in(int_irq_in),
    .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .chan_irq_out(chan_irq_out), .nmi_out(nmi_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input int a, input logic [31:0] d);
    cfg_addr = 6'(a); cfg_wdata = d; cfg_wr_en = 1'b1;
    step();
    cfg_wr_en = 1'b0;
  endtask

  task automatic read_reg(input int a, output logic [31:0] d);
    cfg_addr = 6'(a);
    step();
    d = cfg_rdata;
  endtask

  task automatic quiet();
    ext_irq_in = '0; int_irq_in = '0;
    write_reg(A_EXT_EN, 0); write_reg(A_INT_EN, 0);
    write_reg(A_EXT_NMI, 0); write_reg(A_INT_NMI, 0); write_reg(A_POL, 0);
    step();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 chan", 32'(chan_irq_out), 0);
    check("R1 nmi", 32'(nmi_out), 0);
    read_reg(5, d);     check("R1 dest", d, 0);
    read_reg(A_POL, d); check("R1 pol", d, 0);
  endtask

  task automatic t_route();
    write_reg(3, 7); write_reg(A_EXT_EN, 32'h8);
    ext_irq_in[3] = 1'b1; step();
    check("R2 ext ch7", 32'(chan_irq_out), 32'h40);
    write_reg(20, 22); write_reg(A_INT_EN, 32'h20);
    int_irq_in[5] = 1'b1; step();
    check("R2 int ch22", 32'(chan_irq_out), 32'h0020_0040);
    write_reg(20, 1); step();
    check("R2 ch1", 32'(chan_irq_out), 32'h41);
    quiet();
  endtask

  task automatic t_unrouted();
    logic [31:0] d;
    write_reg(A_EXT_EN, 32'h7); ext_irq_in[2:0] = 3'b111;
    write_reg(0, 0); write_reg(1, 23); write_reg(2, 31); step();
    check("R3 codes 0/23/31", 32'(chan_irq_out), 0);
    read_reg(2, d); check("R10 dest 31", d, 31);
    write_reg(4, 32'hFFFF_FFE9); read_reg(4, d); check("R10 dest width", d, 32'h9);
    quiet();
  endtask

  task automatic t_enable();
    write_reg(3, 7); write_reg(A_EXT_EN, 32'h8); write_reg(A_EXT_NMI, 32'h8);
    ext_irq_in[3] = 1'b1; step();
    check("R4 on", 32'(chan_irq_out), 32'h40);
    write_reg(A_EXT_EN, 0); step();
    check("R4 off chan", 32'(chan_irq_out), 0);
    check("R4 nmi kept", 32'(nmi_out), 1);
    quiet();
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    write_reg(3, 7); write_reg(A_EXT_EN, 32'h8); write_reg(A_POL, 32'h8);
    ext_irq_in[3] = 1'b0; step();
    check("R5 low active", 32'(chan_irq_out), 32'h40);
    ext_irq_in[3] = 1'b1; step();
    check("R5 high idle", 32'(chan_irq_out), 0);
    write_reg(A_POL, 32'hFFFF_FFFF); read_reg(A_POL, d);
    check("R5 pol width", d, 32'h7FFF);
    write_reg(25, 12); write_reg(A_INT_EN, 32'h400); int_irq_in[10] = 1'b1; step();
    check("R5 internal not inverted", 32'(chan_irq_out), 32'h800);
    quiet();
  endtask

  task automatic t_or();
    write_reg(6, 9); write_reg(30, 9); write_reg(A_EXT_EN, 32'h40);
    write_reg(A_INT_EN, 32'h8000);
    ext_irq_in[6] = 1'b1; step();
    check("R6 first", 32'(chan_irq_out), 32'h100);
    ext_irq_in[6] = 1'b0; int_irq_in[15] = 1'b1; step();
    check("R6 second", 32'(chan_irq_out), 32'h100);
    ext_irq_in[6] = 1'b1; step();
    check("R6 both", 32'(chan_irq_out), 32'h100);
    int_irq_in[15] = 1'b0; ext_irq_in[6] = 1'b0; step();
    check("R6 none", 32'(chan_irq_out), 0);
    quiet();
  endtask

  task automatic t_nmi();
    write_reg(A_INT_NMI, 32'h2); int_irq_in[1] = 1'b1; step();
    check("R7 nmi-only line", 32'(nmi_out), 1);
    write_reg(A_INT_NMI, 0); step();
    check("R7 disabled", 32'(nmi_out), 0);
    write_reg(A_EXT_NMI, 32'h1); write_reg(A_POL, 32'h1); step();
    check("R7 ext inverted", 32'(nmi_out), 1);
    ext_irq_in[0] = 1'b1; step();
    check("R7 ext idle", 32'(nmi_out), 0);
    quiet();
  endtask

  task automatic t_forbid();
    logic [31:0] d;
    write_reg(16, 4); write_reg(18, 4); write_reg(A_INT_EN, 32'hA);
    int_irq_in[1] = 1'b1; int_irq_in[3] = 1'b1; step();
    check("R8 nmi-only lines off channels", 32'(chan_irq_out), 0);
    read_reg(18, d); check("R10 forbidden dest stored", d, 4);
    quiet();
    write_reg(17, 9); write_reg(A_INT_EN, 32'h4); write_reg(A_INT_NMI, 32'h4);
    int_irq_in[2] = 1'b1; step();
    check("R9 channel ok", 32'(chan_irq_out), 32'h100);
    check("R9 no nmi", 32'(nmi_out), 0);
    quiet();
    write_reg(15, 2); write_reg(A_INT_EN, 32'h1); write_reg(A_INT_NMI, 32'h1);
    int_irq_in[0] = 1'b1; step();
    check("R8 bridge general channel", 32'(chan_irq_out), 32'h2);
    check("R9 bridge general nmi", 32'(nmi_out), 1);
    quiet();
  endtask

  task automatic t_latency();
    write_reg(3, 7); write_reg(A_EXT_EN, 32'h8); step();
    ext_irq_in[3] = 1'b1;
    #1 check("R11 before edge", 32'(chan_irq_out), 0);
    @(posedge clk);
    #1 check("R11 after edge", 32'(chan_irq_out), 32'h40);
    @(negedge clk);
    quiet();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_route();
    t_unrouted();
    t_enable();
    t_polarity();
    t_or();
    t_nmi();
    t_forbid();
    t_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule